// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Registers

This block is a time-of-day and calendar core with two copies of its registers. A running set of counters advances once for every pulse on a one-second tick input. A second set is the copy that software sees through a simple byte-wide register port with chip select, read strobe, write strobe, address and data. Eight fields are held in packed BCD, with the tens digit in the upper nibble: seconds, minutes, hours (24-hour form), day of week, date, month, two-digit year and century. Month lengths and February in leap years are handled in hardware.

The visible copy normally tracks the running counters, being refreshed on every tick. Two control bits change this. The freeze bit holds the visible copy at the count captured when it was set, so that several bytes can be read as one consistent time. The load bit stops the counting so that software can place new values in the visible copy. Clearing the load bit then copies those values into the running counters, and counting continues from them. A separate stop bit in the seconds register halts timekeeping altogether. Its reset value is "stopped".

The eight registers occupy the top eight addresses of a 2^ADDR_W byte space. Every other address reads as zero and ignores writes.

Top module: `bcd_calendar_regs`

## Requirements
- R1: After reset, the registers read as follows: control 0x00, seconds 0x80 (stop bit set, count 00), minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00.
- R2: Register offsets from the window base (2^ADDR_W-8) are 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month and 7 year. On each counted tick, seconds go 59→00 and carry into minutes, minutes go 59→00 and carry into hours, and hours go 23→00 and carry into the date.
- R3: The day-of-week field counts 1..7, and it steps on each day carry, going from 7 to 1.
- R4: The date rolls back to 01 after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12. A month carry takes the month from 12 to 01.
- R5: February rolls over after 29 when the year field is divisible by 4 (00 counts as a leap year), and after 28 otherwise.
- R6: A month carry out of December increments the year. Year 99 rolls to 00 and increments the century, which is held in control bits 5:0. Century 39 rolls to 00.
- R7: Seconds bit 7 is the stop bit. While it reads 1, ticks do not advance the count. Writing 0 to it restarts counting.
- R8: With control bits 7 and 6 both 0, each tick refreshes the visible registers with the newly advanced count.
- R9: Writing control bit 6 = 1 freezes the visible registers at the count of that moment, while the running counters keep advancing. After the bit is cleared, the old values remain visible until the next tick, which shows the current count.
- R10: While control bit 7 is 1, ticks neither advance the counters nor refresh the visible copy, and register writes change the visible copy. A control write that clears bit 7 copies the visible values, with the century taken from that write, into the counters, and counting resumes from them.
- R11: Addresses below the window read 0x00, and writes to them change nothing. Bits above each field's width read 0: minutes and seconds keep 7 bits, hours and date 6, month 5, and day 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| cs | input | 1 | Chip select, active high |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, zero when not reading a register |

## Verification
The bench builds the block with ADDR_W = 4. This makes the whole address space only sixteen bytes, so the bench can sweep every address below the register window for decode leaks and still reach the window at offsets 8 to 15. Directed loads place the count just before each rollover: minute, hour, day-of-week, 30- and 31-day months, both February cases, year and century. Seeded random loads followed by random tick bursts compare every register against a bench calendar model.

// File: rtl/cal_pkg.sv
package cal_pkg;

   typedef enum logic [2:0] {
      RI_CTRL = 3'd0,
      RI_SEC  = 3'd1,
      RI_MIN  = 3'd2,
      RI_HOUR = 3'd3,
      RI_DOW  = 3'd4,
      RI_DATE = 3'd5,
      RI_MON  = 3'd6,
      RI_YEAR = 3'd7
   } reg_idx_e;

   localparam int CEN_W = 6;
   localparam int DOW_W = 3;

   typedef struct packed {
      logic [CEN_W-1:0] cen;
      logic [7:0]       yr;
      logic [7:0]       mon;
      logic [7:0]       date;
      logic [DOW_W-1:0] dow;
      logic [7:0]       hr;
      logic [7:0]       mn;
      logic [7:0]       sec;
   } cal_t;

   localparam cal_t CAL_RST = '{cen: 6'h00, yr: 8'h00, mon: 8'h01, date: 8'h01,
                                dow: 3'd1, hr: 8'h00, mn: 8'h00, sec: 8'h00};

   // A two-digit BCD year is a multiple of four when (2*tens + ones) is.
   function automatic logic bcd_is_leap(input logic [7:0] y);
      logic [3:0] o;
      o = y[3:0];
      if (y[4]) bcd_is_leap = (o == 4'd2) || (o == 4'd6);
      else      bcd_is_leap = (o == 4'd0) || (o == 4'd4) || (o == 4'd8);
   endfunction

endpackage

// File: rtl/cal_bcd_inc.sv
module cal_bcd_inc #(
   parameter int W  = 8,
   parameter int LO = 0
) (
   input  logic         en,
   input  logic [W-1:0] val,
   input  logic [W-1:0] hi,
   output logic [W-1:0] nxt,
   output logic         carry
);
   localparam int TW = W - 4;

   if (W < 5 || W > 8) begin : g_bad_w
      $error("cal_bcd_inc: W must be 5..8");
   end

   always_comb begin
      nxt   = val;
      carry = 1'b0;
      if (en) begin
         if (val >= hi) begin
            nxt   = W'(LO);
            carry = 1'b1;
         end else if (val[3:0] == 4'd9) begin
            nxt = {val[W-1:4] + TW'(1), 4'h0};
         end else begin
            nxt = val + W'(1);
         end
      end
   end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
   input  logic [7:0] mon,
   input  logic [7:0] yr,
   output logic [7:0] last
);
   import cal_pkg::*;

   always_comb begin
      case (mon)
         8'h02:                      last = bcd_is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last = 8'h30;
         default:                    last = 8'h31;
      endcase
   end
endmodule

// File: rtl/cal_advance.sv
module cal_advance (
   input  logic          en,
   input  cal_pkg::cal_t cur,
   output cal_pkg::cal_t nxt
);
   import cal_pkg::*;

   logic c_sec, c_min, c_hr, c_date, c_mon, c_yr, c_cen;
   logic [7:0] last_date;

   cal_month_len u_len (.mon(cur.mon), .yr(cur.yr), .last(last_date));

   cal_bcd_inc #(.W(8), .LO(0)) u_sec
      (.en(en),     .val(cur.sec),  .hi(8'h59), .nxt(nxt.sec),  .carry(c_sec));
   cal_bcd_inc #(.W(8), .LO(0)) u_min
      (.en(c_sec),  .val(cur.mn),   .hi(8'h59), .nxt(nxt.mn),   .carry(c_min));
   cal_bcd_inc #(.W(8), .LO(0)) u_hr
      (.en(c_min),  .val(cur.hr),   .hi(8'h23), .nxt(nxt.hr),   .carry(c_hr));
   cal_bcd_inc #(.W(8), .LO(1)) u_date
      (.en(c_hr),   .val(cur.date), .hi(last_date), .nxt(nxt.date), .carry(c_date));
   cal_bcd_inc #(.W(8), .LO(1)) u_mon
      (.en(c_date), .val(cur.mon),  .hi(8'h12), .nxt(nxt.mon),  .carry(c_mon));
   cal_bcd_inc #(.W(8), .LO(0)) u_yr
      (.en(c_mon),  .val(cur.yr),   .hi(8'h99), .nxt(nxt.yr),   .carry(c_yr));
   cal_bcd_inc #(.W(CEN_W), .LO(0)) u_cen
      (.en(c_yr),   .val(cur.cen),  .hi(6'h39), .nxt(nxt.cen),  .carry(c_cen));

   always_comb begin
      nxt.dow = cur.dow;
      if (c_hr) nxt.dow = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
   end

   // The century carry leaves the block unused by design; fold it in harmlessly.
   logic unused_carry;
   assign unused_carry = c_cen;
endmodule

// File: rtl/bcd_calendar_regs.sv
module bcd_calendar_regs #(
   parameter int   ADDR_W      = 13,
   parameter logic RST_STOPPED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              cs,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);
   import cal_pkg::*;

   localparam logic [ADDR_W-1:0] BASE = ADDR_W'((1 << ADDR_W) - 8);

   if (ADDR_W < 3 || ADDR_W > 24) begin : g_bad_aw
      $error("bcd_calendar_regs: ADDR_W must be 3..24");
   end

   cal_t     int_q, int_nxt, int_d, ext_q, ext_d, commit_val;
   logic     rb_q, wb_q, stop_q, rb_d, wb_d, stop_d;
   logic     hit, wr, rd, adv_en, commit;
   reg_idx_e idx;

   assign hit    = (addr >= BASE);
   assign idx    = reg_idx_e'(3'(addr - BASE));
   assign wr     = cs && wr_en && hit;
   assign rd     = cs && rd_en && hit;
   assign adv_en = sec_tick && !stop_q && !wb_q;
   assign commit = wr && (idx == RI_CTRL) && wb_q && !wdata[7];

   cal_advance u_adv (.en(adv_en), .cur(int_q), .nxt(int_nxt));

   always_comb begin
      commit_val     = ext_q;
      commit_val.cen = wdata[5:0];
      int_d          = commit ? commit_val : int_nxt;
   end

   always_comb begin
      ext_d  = ext_q;
      rb_d   = rb_q;
      wb_d   = wb_q;
      stop_d = stop_q;
      if (sec_tick && !rb_q && !wb_q) ext_d = int_nxt;
      if (wr) begin
         case (idx)
            RI_CTRL: begin
               wb_d = wdata[7];
               rb_d = wdata[6];
               if (wdata[6] && !wdata[7] && !rb_q && !wb_q) ext_d = int_q;
               else ext_d.cen = wdata[5:0];
            end
            RI_SEC: begin
               ext_d.sec = {1'b0, wdata[6:0]};
               stop_d    = wdata[7];
            end
            RI_MIN:  ext_d.mn   = {1'b0, wdata[6:0]};
            RI_HOUR: ext_d.hr   = {2'b0, wdata[5:0]};
            RI_DOW:  ext_d.dow  = wdata[2:0];
            RI_DATE: ext_d.date = {2'b0, wdata[5:0]};
            RI_MON:  ext_d.mon  = {3'b0, wdata[4:0]};
            default: ext_d.yr   = wdata;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_q  <= CAL_RST;
         ext_q  <= CAL_RST;
         rb_q   <= 1'b0;
         wb_q   <= 1'b0;
         stop_q <= RST_STOPPED;
      end else begin
         int_q  <= int_d;
         ext_q  <= ext_d;
         rb_q   <= rb_d;
         wb_q   <= wb_d;
         stop_q <= stop_d;
      end
   end

   always_comb begin
      rdata = 8'h00;
      if (rd) begin
         case (idx)
            RI_CTRL: rdata = {wb_q, rb_q, ext_q.cen};
            RI_SEC:  rdata = {stop_q, ext_q.sec[6:0]};
            RI_MIN:  rdata = ext_q.mn;
            RI_HOUR: rdata = ext_q.hr;
            RI_DOW:  rdata = {5'b0, ext_q.dow};
            RI_DATE: rdata = ext_q.date;
            RI_MON:  rdata = ext_q.mon;
            default: rdata = ext_q.yr;
         endcase
      end
   end

   // R7
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !commit) |=> $stable(int_q));
   // R9
   read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_q && !wr) |=> $stable(ext_q));
   // R10
   write_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_q && !commit) |=> $stable(int_q));
   // R8
   refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !rb_q && !wb_q && !wr) |=> (ext_q == int_q));
   // R6
   year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && !commit && int_q.yr == 8'h99 && int_q.mon == 8'h12 &&
       int_q.date == 8'h31 && int_q.hr == 8'h23 && int_q.mn == 8'h59 &&
       int_q.sec == 8'h59)
      |=> (int_q.yr == 8'h00 && int_q.mon == 8'h01 && int_q.date == 8'h01));
   // R3
   dow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && !commit && int_q.dow == 3'd7 && int_q.hr == 8'h23 &&
       int_q.mn == 8'h59 && int_q.sec == 8'h59) |=> (int_q.dow == 3'd1));
endmodule

// File: tb/sim_bcd_calendar_regs.sv
`timescale 1ns/1ps
module sim_bcd_calendar_regs;
   localparam int AW   = 4;
   localparam int BASE = (1 << AW) - 8;

   logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0;
   logic cs = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0] wdata = 8'h00, rdata;

   always #2 clk = ~clk;

   bcd_calendar_regs #(.ADDR_W(AW)) u0 (.clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
      .cs(cs), .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata));

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // bench model: running counters, visible image, control bits
   int m_cen, m_yr, m_mon, m_date, m_dow, m_hr, m_min, m_sec;
   bit m_stop, m_rb, m_wb;
   logic [7:0] ximg [8];

   function automatic logic [7:0] b(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int dim(input int mon, input int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   function automatic void snap();
      ximg[0] = b(m_cen); ximg[1] = b(m_sec); ximg[2] = b(m_min); ximg[3] = b(m_hr);
      ximg[4] = b(m_dow); ximg[5] = b(m_date); ximg[6] = b(m_mon); ximg[7] = b(m_yr);
   endfunction

   function automatic void m_advance();
      m_sec++;
      if (m_sec == 60) begin
         m_sec = 0; m_min++;
         if (m_min == 60) begin
            m_min = 0; m_hr++;
            if (m_hr == 24) begin
               m_hr = 0;
               m_dow = (m_dow == 7) ? 1 : m_dow + 1;
               m_date++;
               if (m_date > dim(m_mon, m_yr)) begin
                  m_date = 1; m_mon++;
                  if (m_mon == 13) begin
                     m_mon = 1; m_yr++;
                     if (m_yr == 100) begin
                        m_yr = 0;
                        m_cen = (m_cen == 39) ? 0 : m_cen + 1;
                     end
                  end
               end
            end
         end
      end
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h exp %02h", tag, got, exp);
      end
   endtask

   task automatic rd_raw(input int a, output logic [7:0] v);
      @(negedge clk);
      addr = AW'(a); cs = 1'b1; rd_en = 1'b1;
      #1 v = rdata;
      cs = 1'b0; rd_en = 1'b0;
   endtask

   task automatic wr_raw(input int a, input logic [7:0] d);
      @(negedge clk);
      addr = AW'(a); wdata = d; cs = 1'b1; wr_en = 1'b1;
      @(negedge clk);
      cs = 1'b0; wr_en = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      if (!m_stop && !m_wb) m_advance();
      if (!m_rb && !m_wb) snap();
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic check_all(input string tag);
      logic [7:0] v;
      for (int i = 0; i < 8; i++) begin
         rd_raw(BASE + i, v);
         if (i == 0)      check(tag, v, {m_wb, m_rb, ximg[0][5:0]});
         else if (i == 1) check(tag, v, {m_stop, ximg[1][6:0]});
         else             check(tag, v, ximg[i]);
      end
   endtask

   task automatic load(input int cen, input int yr, input int mon, input int date,
                       input int dow, input int hr, input int mn, input int sec);
      wr_raw(BASE + 0, 8'h80 | b(cen));
      wr_raw(BASE + 1, b(sec));
      wr_raw(BASE + 2, b(mn));
      wr_raw(BASE + 3, b(hr));
      wr_raw(BASE + 4, b(dow));
      wr_raw(BASE + 5, b(date));
      wr_raw(BASE + 6, b(mon));
      wr_raw(BASE + 7, b(yr));
      wr_raw(BASE + 0, b(cen));
      m_cen = cen; m_yr = yr; m_mon = mon; m_date = date; m_dow = dow;
      m_hr = hr; m_min = mn; m_sec = sec;
      m_stop = 1'b0; m_rb = 1'b0; m_wb = 1'b0;
      snap();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int unsigned seed;
      seed = $urandom(32'h5EED);
      m_cen = 0; m_yr = 0; m_mon = 1; m_date = 1; m_dow = 1; m_hr = 0; m_min = 0; m_sec = 0;
      m_stop = 1'b1; m_rb = 1'b0; m_wb = 1'b0;
      snap();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset image, stopped clock ignores ticks (R7)
      check_all("R1 reset");
      ticks(3);
      check_all("R7 stopped after reset");

      // R2 minute/hour/day carry; R3 day of week 7 -> 1
      load(20, 23, 6, 14, 7, 23, 59, 58);
      ticks(1);
      check_all("R2 pre-carry");
      ticks(1);
      check_all("R2 R3 day carry");

      // R4 30-day and 31-day months, December wrap
      load(20, 23, 4, 30, 2, 23, 59, 59);
      ticks(1);
      check_all("R4 april end");
      load(20, 23, 1, 31, 2, 23, 59, 59);
      ticks(1);
      check_all("R4 january end");

      // R5 February, non-leap and leap, and year 00
      load(20, 23, 2, 28, 3, 23, 59, 59);
      ticks(1);
      check_all("R5 non-leap feb");
      load(20, 24, 2, 28, 3, 23, 59, 59);
      ticks(1);
      check_all("R5 leap feb 29");
      load(20, 24, 2, 29, 4, 23, 59, 59);
      ticks(1);
      check_all("R5 leap feb end");
      load(21, 0, 2, 28, 4, 23, 59, 59);
      ticks(1);
      check_all("R5 year 00 leap");

      // R6 year and century carries
      load(19, 99, 12, 31, 5, 23, 59, 59);
      ticks(1);
      check_all("R6 century carry");
      load(39, 99, 12, 31, 5, 23, 59, 59);
      ticks(1);
      check_all("R6 century wrap");

      // R9 freeze while counters run, stale until next tick after release
      load(20, 30, 8, 8, 1, 10, 0, 0);
      wr_raw(BASE + 0, 8'h40 | b(m_cen)); m_rb = 1'b1;
      ticks(3);
      check_all("R9 frozen");
      wr_raw(BASE + 0, b(m_cen)); m_rb = 1'b0;
      check_all("R9 stale after release");
      ticks(1);
      check_all("R9 R8 refreshed");
      check("R9 seconds advanced", ximg[1], 8'h04);

      // R7 stop and restart by seconds bit 7
      wr_raw(BASE + 1, 8'h80 | b(m_sec)); m_stop = 1'b1;
      ticks(4);
      check_all("R7 stopped");
      wr_raw(BASE + 1, b(m_sec)); m_stop = 1'b0;
      ticks(2);
      check_all("R7 restarted");

      // R10 ticks held while load bit set, edits visible, commit resumes
      wr_raw(BASE + 0, 8'h80 | b(m_cen)); m_wb = 1'b1;
      wr_raw(BASE + 3, 8'h07); ximg[3] = 8'h07;
      ticks(3);
      check_all("R10 halted edit");
      wr_raw(BASE + 0, b(m_cen)); m_wb = 1'b0; m_hr = 7;
      ticks(2);
      check_all("R10 committed");

      // R11 field masks
      wr_raw(BASE + 0, 8'h80 | b(m_cen));
      wr_raw(BASE + 4, 8'hFF); rd_raw(BASE + 4, v); check("R11 day mask", v, 8'h07);
      wr_raw(BASE + 6, 8'hFF); rd_raw(BASE + 6, v); check("R11 month mask", v, 8'h1F);
      wr_raw(BASE + 3, 8'hFF); rd_raw(BASE + 3, v); check("R11 hour mask", v, 8'h3F);
      wr_raw(BASE + 2, 8'hFF); rd_raw(BASE + 2, v); check("R11 minute mask", v, 8'h7F);
      load(20, 45, 3, 3, 3, 3, 3, 3);

      // R11 addresses below the window
      for (int a = 0; a < BASE; a++) begin
         rd_raw(a, v);
         check("R11 below window read", v, 8'h00);
         wr_raw(a, 8'hFF);
      end
      check_all("R11 below window write");

      // random loads and tick bursts
      for (int it = 0; it < 30; it++) begin
         int mo, yr;
         mo = 1 + int'($urandom_range(11));
         yr = int'($urandom_range(99));
         load(int'($urandom_range(39)), yr, mo, 1 + int'($urandom_range(dim(mo, yr) - 1)),
              1 + int'($urandom_range(6)), int'($urandom_range(23)),
              int'($urandom_range(59)), 40 + int'($urandom_range(19)));
         ticks(int'($urandom_range(120)));
         check_all("R2 R4 R5 random");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule